// File: doc/BRIEF.md
# Rotating-Parity Small-Write Sequencer

This block takes one logical block write aimed at a five-column disk array. In the array each stripe holds four data blocks and one parity block, and the parity block moves one column to the left on each successive stripe. The block works out which stripe the logical block number falls in, which column holds the data and which holds the parity. It then updates the parity with a read-modify-write sequence on a word-wide physical disk port. The new parity is the old data XOR the new data XOR the old parity, worked out one word at a time as the old blocks stream into a local buffer.

The host side accepts a whole block, given as a flat vector of words, with a valid/ready handshake. Only one write can be in progress at a time. The disk side moves one word per transfer, and each transfer finishes when the disk raises an acknowledge. A one-cycle completion pulse marks the end of each logical write.

Top module: `r5sw_top`

## Requirements
- R1: The parity column of stripe s is column 4 − (s mod 5): stripe 0 uses column 4, stripe 4 uses column 0, and the pattern repeats from stripe 5.
- R2: Logical block L lies in stripe L / 4 and is unit u = L mod 4 of that stripe. Its data column is u when u is below the parity column, and u + 1 otherwise.
- R3: Each accepted write issues exactly four physical block operations, in this order: read the data column, read the parity column, write the data column, write the parity column.
- R4: Every parity word written equals the old data word XOR the new data word XOR the old parity word at the same word index.
- R5: After completion the data column holds the new block, and no other block in the array has changed.
- R6: req_ready is high when idle and stays low from acceptance until the final parity word is acknowledged. A request held valid during that time is not taken.
- R7: A word transfer keeps dk_req, the address and the write data steady until dk_ack. Each block operation moves BLK_WORDS words with dk_widx counting up from 0.
- R8: done is high for exactly one cycle: the cycle right after the acknowledge of the last parity word.
- R9: Out of reset, req_ready is 1, and dk_req and done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host write request valid |
| req_ready | output | 1 | Sequencer can accept a write |
| req_lba | input | LBA_W | Logical block number |
| req_blk | input | BLK_WORDS*WORD_W | New block contents, word 0 in the low bits |
| done | output | 1 | One-cycle completion pulse |
| dk_req | output | 1 | Disk word transfer request |
| dk_we | output | 1 | 1 = write, 0 = read |
| dk_col | output | 3 | Disk column 0..4 |
| dk_stripe | output | LBA_W-2 | Stripe (block row) on the column |
| dk_widx | output | $clog2(BLK_WORDS) | Word index inside the block |
| dk_wdata | output | WORD_W | Write data |
| dk_ack | input | 1 | Disk acknowledge; read data valid with it |
| dk_rdata | input | WORD_W | Read data |

## Verification
The bench builds the block with LBA_W = 6, WORD_W = 16 and BLK_WORDS = 4. That gives sixteen stripes, so writes can land on every parity position and also wrap past stripe 5. Four words per block are enough to check that the buffer XOR works at each word index, and that it works both with immediate acknowledges and when acknowledges are held off for several cycles. The model disk starts with a distinct pattern in every word, so a stray write to any column shows up in the comparison of the whole array.

// File: rtl/r5sw_pkg.sv
package r5sw_pkg;
  localparam int NCOL  = 5;
  localparam int DPS   = NCOL - 1;
  localparam int COL_W = 3;

  typedef enum logic [2:0] {
    PH_IDLE, PH_RD_DATA, PH_RD_PAR, PH_WR_DATA, PH_WR_PAR
  } phase_t;

  function automatic logic [COL_W-1:0] par_col_of(input int unsigned stripe);
    return COL_W'(DPS - int'(stripe % NCOL));
  endfunction

  function automatic logic [COL_W-1:0] dat_col_of(input logic [COL_W-1:0] unit,
                                                  input logic [COL_W-1:0] pcol);
    return (unit >= pcol) ? unit + COL_W'(1) : unit;
  endfunction
endpackage

// File: rtl/r5sw_map.sv
module r5sw_map
  import r5sw_pkg::*;
#(
  parameter int LBA_W = 12
) (
  input  logic [LBA_W-1:0]   lba,
  output logic [LBA_W-3:0]   stripe,
  output logic [COL_W-1:0]   dcol,
  output logic [COL_W-1:0]   pcol
);
  localparam int UNIT_W = $clog2(DPS);

  logic [UNIT_W-1:0] unit;

  always_comb begin
    unit   = lba[UNIT_W-1:0];
    stripe = lba[LBA_W-1:UNIT_W];
    pcol   = par_col_of(32'(stripe));
    dcol   = dat_col_of(COL_W'(unit), pcol);
  end
endmodule

// File: rtl/r5sw_buf.sv
module r5sw_buf #(
  parameter int WORD_W    = 32,
  parameter int BLK_WORDS = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic [BLK_WORDS*WORD_W-1:0] blk_in,
  input  logic                        fold_data,
  input  logic                        fold_par,
  input  logic [$clog2(BLK_WORDS)-1:0] idx,
  input  logic [WORD_W-1:0]           rdata,
  output logic [WORD_W-1:0]           new_word,
  output logic [WORD_W-1:0]           par_word
);
  logic [WORD_W-1:0] nbuf [BLK_WORDS];
  logic [WORD_W-1:0] pbuf [BLK_WORDS];

  for (genvar g = 0; g < BLK_WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        nbuf[g] <= '0;
        pbuf[g] <= '0;
      end else begin
        if (load) nbuf[g] <= blk_in[g*WORD_W +: WORD_W];
        if (fold_data && idx == g) pbuf[g] <= rdata ^ nbuf[g];
        else if (fold_par && idx == g) pbuf[g] <= pbuf[g] ^ rdata;
      end
    end
  end

  assign new_word = nbuf[idx];
  assign par_word = pbuf[idx];
endmodule

// File: rtl/r5sw_seq.sv
module r5sw_seq
  import r5sw_pkg::*;
#(
  parameter int BLK_WORDS = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic                         dk_ack,
  output phase_t                       phase,
  output logic [$clog2(BLK_WORDS)-1:0] widx,
  output logic                         beat_last,
  output logic                         done
);
  localparam int IDX_W = $clog2(BLK_WORDS);

  logic op_end;

  assign beat_last = (widx == IDX_W'(BLK_WORDS - 1));
  assign op_end    = dk_ack && beat_last && (phase != PH_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      widx  <= '0;
      done  <= 1'b0;
    end else begin
      done <= op_end && (phase == PH_WR_PAR);
      if (phase == PH_IDLE) begin
        widx <= '0;
        if (start) phase <= PH_RD_DATA;
      end else if (dk_ack) begin
        widx <= beat_last ? '0 : widx + IDX_W'(1);
        if (beat_last) begin
          unique case (phase)
            PH_RD_DATA: phase <= PH_RD_PAR;
            PH_RD_PAR:  phase <= PH_WR_DATA;
            PH_WR_DATA: phase <= PH_WR_PAR;
            default:    phase <= PH_IDLE;
          endcase
        end
      end
    end
  end

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && !dk_ack) |=> $stable(widx) && $stable(phase));
endmodule

// File: rtl/r5sw_top.sv
module r5sw_top
  import r5sw_pkg::*;
#(
  parameter int LBA_W     = 12,
  parameter int WORD_W    = 32,
  parameter int BLK_WORDS = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [LBA_W-1:0]              req_lba,
  input  logic [BLK_WORDS*WORD_W-1:0]   req_blk,
  output logic                          done,
  output logic                          dk_req,
  output logic                          dk_we,
  output logic [2:0]                    dk_col,
  output logic [LBA_W-3:0]              dk_stripe,
  output logic [$clog2(BLK_WORDS)-1:0]  dk_widx,
  input  logic                          dk_ack,
  output logic [WORD_W-1:0]             dk_wdata,
  input  logic [WORD_W-1:0]             dk_rdata
);
  localparam int STR_W = LBA_W - 2;
  localparam int IDX_W = $clog2(BLK_WORDS);

  phase_t            phase;
  logic              accept, beat_last;
  logic [STR_W-1:0]  map_stripe, stripe_q;
  logic [COL_W-1:0]  map_dcol, map_pcol, dcol_q, pcol_q;
  logic [IDX_W-1:0]  widx;
  logic [WORD_W-1:0] new_word, par_word;
  logic              data_phase;

  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_valid && req_ready;

  r5sw_map #(.LBA_W(LBA_W)) u_map (
    .lba(req_lba), .stripe(map_stripe), .dcol(map_dcol), .pcol(map_pcol)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stripe_q <= '0;
      dcol_q   <= '0;
      pcol_q   <= '0;
    end else if (accept) begin
      stripe_q <= map_stripe;
      dcol_q   <= map_dcol;
      pcol_q   <= map_pcol;
    end
  end

  r5sw_seq #(.BLK_WORDS(BLK_WORDS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .dk_ack(dk_ack),
    .phase(phase), .widx(widx), .beat_last(beat_last), .done(done)
  );

  r5sw_buf #(.WORD_W(WORD_W), .BLK_WORDS(BLK_WORDS)) u_buf (
    .clk(clk), .rst_n(rst_n), .load(accept), .blk_in(req_blk),
    .fold_data(dk_ack && phase == PH_RD_DATA),
    .fold_par(dk_ack && phase == PH_RD_PAR),
    .idx(widx), .rdata(dk_rdata), .new_word(new_word), .par_word(par_word)
  );

  assign data_phase = (phase == PH_RD_DATA) || (phase == PH_WR_DATA);
  assign dk_req     = (phase != PH_IDLE);
  assign dk_we      = (phase == PH_WR_DATA) || (phase == PH_WR_PAR);
  assign dk_col     = data_phase ? dcol_q : pcol_q;
  assign dk_stripe  = stripe_q;
  assign dk_widx    = widx;
  assign dk_wdata   = (phase == PH_WR_DATA) ? new_word : par_word;

  a_r1_cols_distinct: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (map_dcol != map_pcol) && (map_pcol <= 3'd4) && (map_dcol <= 3'd4));
  a_r6_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    dk_req |-> !req_ready);
  a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dk_req && !dk_ack) |=> dk_req && $stable(dk_col) && $stable(dk_we) &&
                            $stable(dk_wdata) && $stable(dk_stripe));
  a_r3_last_is_parity_write: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(dk_we) && $past(dk_ack) && ($past(dk_col) == pcol_q));
endmodule

// File: tb/r5sw_top_tb.sv
module r5sw_top_tb;
  localparam int CLK_P = 10;
  localparam int LW = 6, WW = 16, BW = 4, NS = 16;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready, done;
  logic [LW-1:0] req_lba = '0;
  logic [BW*WW-1:0] req_blk = '0;
  logic dk_req, dk_we, dk_ack;
  logic [2:0] dk_col;
  logic [LW-3:0] dk_stripe;
  logic [1:0] dk_widx;
  logic [WW-1:0] dk_wdata, dk_rdata;

  always #(CLK_P/2) clk = ~clk;

  r5sw_top #(.LBA_W(LW), .WORD_W(WW), .BLK_WORDS(BW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_lba(req_lba), .req_blk(req_blk), .done(done), .dk_req(dk_req),
    .dk_we(dk_we), .dk_col(dk_col), .dk_stripe(dk_stripe), .dk_widx(dk_widx),
    .dk_ack(dk_ack), .dk_wdata(dk_wdata), .dk_rdata(dk_rdata));

  logic [WW-1:0] mem  [5][NS][BW];
  logic [WW-1:0] snap [5][NS][BW];
  int stall_n = 0, wcnt = 0, nops = 0, nbeats = 0, bad_idx = 0;
  logic [3:0] oplog [8];
  int npass = 0, nfail = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      dk_ack <= 0; dk_rdata <= '0; wcnt <= 0;
    end else if (dk_ack) dk_ack <= 0;
    else if (dk_req) begin
      if (wcnt >= stall_n) begin
        dk_ack <= 1; wcnt <= 0;
        if (dk_we) mem[dk_col][dk_stripe][dk_widx] <= dk_wdata;
        else dk_rdata <= mem[dk_col][dk_stripe][dk_widx];
        if (int'(dk_widx) != nbeats % BW) bad_idx++;
        if (dk_widx == 0) begin
          if (nops < 8) oplog[nops] = {dk_we, dk_col};
          nops++;
        end
        nbeats++;
      end else wcnt <= wcnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    if (ok) npass++;
    else begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int ref_pcol(input int s);
    case (s % 5)
      0: return 4; 1: return 3; 2: return 2; 3: return 1; default: return 0;
    endcase
  endfunction

  function automatic int ref_dcol(input int l);
    int p = ref_pcol(l / 4), k = 0;
    for (int c = 0; c < 5; c++) if (c != p) begin
      if (k == l % 4) return c;
      k++;
    end
    return -1;
  endfunction

  task automatic do_write(input int lba, input int seed, input int stall, input bit hold);
    int s = lba / 4, p = ref_pcol(s), d = ref_dcol(lba);
    logic [WW-1:0] nw [BW];
    bit lastpar = 0, saw_ready = 0, got = 0;
    int diffs = 0, pbad = 0, dbad = 0;
    snap = mem;
    for (int i = 0; i < BW; i++) begin
      nw[i] = WW'(seed * 16'h1357 + i * 16'h0f0f);
      req_blk[i*WW +: WW] = nw[i];
    end
    @(negedge clk);
    stall_n = stall; nops = 0; nbeats = 0; bad_idx = 0;
    chk(req_ready == 1, "R6 ready before request", req_ready, 1);
    req_lba = LW'(lba); req_valid = 1;
    @(negedge clk);
    if (hold) begin req_lba = LW'(lba + 1); req_blk = ~req_blk; end
    else req_valid = 0;
    for (int t = 0; t < 2000 && !got; t++) begin
      if (done) begin
        got = 1;
        chk(lastpar, "R8 done follows final parity ack", lastpar, 1);
      end else begin
        if (req_ready) saw_ready = 1;
        lastpar = dk_ack && dk_we && (int'(dk_col) == p) && (dk_widx == BW-1);
        @(negedge clk);
      end
    end
    req_valid = 0;
    chk(got, "R8 done seen", got, 1);
    chk(!saw_ready, "R6 ready low while busy", saw_ready, 0);
    @(negedge clk);
    chk(!done, "R8 done one cycle", done, 0);
    chk(req_ready && !dk_req, "R6 idle after done", {req_ready, dk_req}, 2'b10);
    chk(nops == 4, "R3 four operations", nops, 4);
    chk(oplog[0] == {1'b0, 3'(d)}, "R2 read old data column", oplog[0], {1'b0, 3'(d)});
    chk(oplog[1] == {1'b0, 3'(p)}, "R1 read old parity column", oplog[1], {1'b0, 3'(p)});
    chk(oplog[2] == {1'b1, 3'(d)}, "R3 write data third", oplog[2], {1'b1, 3'(d)});
    chk(oplog[3] == {1'b1, 3'(p)}, "R3 write parity last", oplog[3], {1'b1, 3'(p)});
    chk(nbeats == 4*BW && bad_idx == 0, "R7 beat count and order", nbeats, 4*BW);
    for (int i = 0; i < BW; i++) begin
      if (mem[d][s][i] != nw[i]) dbad++;
      if (mem[p][s][i] != (snap[d][s][i] ^ nw[i] ^ snap[p][s][i])) pbad++;
    end
    chk(dbad == 0, "R5 data column updated", dbad, 0);
    chk(pbad == 0, "R4 parity words", pbad, 0);
    for (int c = 0; c < 5; c++) for (int r = 0; r < NS; r++) for (int i = 0; i < BW; i++)
      if (!(r == s && (c == p || c == d)) && mem[c][r][i] != snap[c][r][i]) diffs++;
    chk(diffs == 0, "R5 other blocks untouched", diffs, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", npass, npass + nfail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 5; c++) for (int r = 0; r < NS; r++) for (int i = 0; i < BW; i++)
      mem[c][r][i] = WW'(c * 16'h1000 + r * 16'h0100 + i * 16'h0011 + 16'h0005);
    repeat (3) @(negedge clk);
    chk(req_ready == 1 && dk_req == 0 && done == 0, "R9 reset state",
        {req_ready, dk_req, done}, 3'b100);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1 && dk_req == 0 && done == 0, "R9 idle after reset",
        {req_ready, dk_req, done}, 3'b100);
    do_write(0, 1, 0, 0);   // stripe 0, parity col 4
    do_write(7, 2, 2, 0);   // stripe 1, unit 3 lands in col 4
    do_write(9, 3, 0, 0);   // stripe 2, parity col 2
    do_write(14, 4, 3, 0);  // stripe 3, parity col 1, unit 2 -> col 3
    do_write(16, 5, 1, 0);  // stripe 4, parity col 0
    do_write(23, 6, 0, 0);  // stripe 5 wraps to parity col 4
    do_write(6, 7, 1, 1);   // R6: valid held busy
    do_write(7, 8, 0, 0);   // back to back on same stripe
    do_write(5, 9, 4, 0);
    do_write(63, 10, 0, 0); // last block
    $display("%0d/%0d checks passed", npass, npass + nfail);
    $finish;
  end
endmodule